// File: doc/BRIEF.md
# Guest Intercept Decision Unit

This unit decides, for each guest operation reported to it, whether that operation must leave the guest and hand control to the host. An operation is given as an exit code, a 64-bit parameter and, for model-specific-register accesses, the register number. The unit holds a set of intercept masks, loaded together by a single strobe. Each code range is decoded against its own mask: control-register reads and writes, debug-register reads and writes, exceptions, and a 64-bit general vector for everything else. One intercept-enable input overrides all of them.

Register-access codes are resolved through a permission map kept in memory, with two bits per register number. When the general vector asks for register accesses to be checked, the unit turns the register number into a byte address and a bit number. It then issues one byte read on a simple read port, raises busy, and gives its decision once the byte comes back. Every other code is decided in the cycle after it is offered.

Top module: `guest_exit_filter`

## Requirements
- R1: After reset, dec_valid, busy and mem_rd are low and every mask and the map base are zero. Until the first load, an enabled request therefore never requests an exit.
- R2: While guard_on is low when a request is accepted, the decision has dec_exit low for every code, and no memory read is issued.
- R3: Codes 0..8 test bit (code) of the control-register read mask. Codes 16..24 test bit (code-16) of the control-register write mask.
- R4: Codes 32..39 test bit (code-32) of the debug-register read mask. Codes 48..55 test bit (code-48) of the debug-register write mask.
- R5: Codes 64..95 test bit (code-64) of the 32-bit exception mask.
- R6: Any other code from 96 to 159 except 124 tests bit (code-96) of the general vector. A code in no range (9..15, 25..31, 40..47, 56..63, 160 and up) gives no exit.
- R7: Code 124 is a register access. If bit 28 of the general vector is clear, it is decided in one cycle with no exit and no memory read.
- R8: With bit 28 set, a register number N in 0x0..0x1FFF uses index N. N in 0xC0000000..0xC0001FFF uses 8192+(N-0xC0000000), and N in 0xC0010000..0xC0011FFF uses 16384+(N-0xC0010000). One read is issued at mem_addr = map_base + (2*index)/8, with mem_rd high for one cycle, in the cycle after the request.
- R9: The decision for a mapped register access is bit ((2*index) mod 8) + param[0] of the returned byte, where param[0]=0 means read and 1 means write.
- R10: With bit 28 set, a register number outside all three windows requests an exit in one cycle without a memory read.
- R11: busy is high from the cycle after a mapped access is accepted until the cycle after mem_rvalid. The decision appears in that cycle. Requests offered while busy is high are ignored and produce no decision.
- R12: A decision is a one-cycle dec_valid pulse with dec_code and dec_param equal to the accepted request. A decision without a memory read appears in the cycle after the request.
- R13: A load strobe replaces all masks, the general vector and the map base at the clock edge. A request at the same edge still uses the old values, and requests from the next cycle on use the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_on | input | 1 | Intercepts enabled |
| ld | input | 1 | Load strobe for masks and map base |
| ld_cr_rd | input | 16 | Control-register read mask |
| ld_cr_wr | input | 16 | Control-register write mask |
| ld_dr_rd | input | 16 | Debug-register read mask |
| ld_dr_wr | input | 16 | Debug-register write mask |
| ld_exc | input | 32 | Exception mask |
| ld_gen | input | 64 | General intercept vector |
| ld_map_base | input | ADDR_W | Permission map byte base address |
| req_valid | input | 1 | Request offered |
| req_code | input | CODE_W | Exit code of the operation |
| req_param | input | 64 | Operation parameter |
| req_msr | input | 32 | Register number for code 124 |
| busy | output | 1 | Map read outstanding |
| mem_rd | output | 1 | Map byte read strobe |
| mem_addr | output | ADDR_W | Map byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| dec_valid | output | 1 | Decision pulse |
| dec_exit | output | 1 | Exit requested |
| dec_code | output | CODE_W | Exit code of the decided request |
| dec_param | output | 64 | Parameter of the decided request |

## Verification
A corrupted mask bit or a wrong range offset shows as a wrong dec_exit in the cycle right after the request, so the reference comparison catches it at the first code that touches the bad bit. A wrong window translation shows first on mem_addr, one cycle after the request and before any data returns. A wrong bit select within the byte shows only when the byte comes back. A stuck or early-released busy shows at once as a busy mismatch, a missing decision pulse, or a decision for a request that should have been ignored.

// File: rtl/guest_exit_filter.sv
module guest_exit_filter #(
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CR_RD_BASE = 0,
  parameter int unsigned CR_WR_BASE = 16,
  parameter int unsigned DR_RD_BASE = 32,
  parameter int unsigned DR_WR_BASE = 48,
  parameter int unsigned EXC_BASE   = 64,
  parameter int unsigned GEN_BASE   = 96,
  parameter int unsigned MSR_CODE   = 124
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_on,
  input  logic              ld,
  input  logic [15:0]       ld_cr_rd,
  input  logic [15:0]       ld_cr_wr,
  input  logic [15:0]       ld_dr_rd,
  input  logic [15:0]       ld_dr_wr,
  input  logic [31:0]       ld_exc,
  input  logic [63:0]       ld_gen,
  input  logic [ADDR_W-1:0] ld_map_base,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [63:0]       req_param,
  input  logic [31:0]       req_msr,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              dec_valid,
  output logic              dec_exit,
  output logic [CODE_W-1:0] dec_code,
  output logic [63:0]       dec_param
);
  localparam int unsigned MSR_BIT = MSR_CODE - GEN_BASE;
  localparam int unsigned CR_N = 9;
  localparam int unsigned DR_N = 8;
  localparam int unsigned EXC_N = 32;
  localparam int unsigned GEN_N = 64;

  logic [15:0] cr_rd, cr_wr, dr_rd, dr_wr;
  logic [31:0] exc;
  logic [63:0] gen;
  logic [ADDR_W-1:0] map_base;
  logic [2:0] pend_bit;

  logic [31:0] c32, o_crr, o_crw, o_drr, o_drw, o_exc, o_gen;
  assign c32   = 32'(req_code);
  assign o_crr = c32 - CR_RD_BASE;
  assign o_crw = c32 - CR_WR_BASE;
  assign o_drr = c32 - DR_RD_BASE;
  assign o_drw = c32 - DR_WR_BASE;
  assign o_exc = c32 - EXC_BASE;
  assign o_gen = c32 - GEN_BASE;

  logic win0, win1, win2, win_any;
  logic [14:0] idx;
  assign win0 = (req_msr[31:13] == 19'h00000);
  assign win1 = (req_msr[31:13] == 19'h60000);
  assign win2 = (req_msr[31:13] == 19'h60008);
  assign win_any = win0 | win1 | win2;
  assign idx = {win2, win1, req_msr[12:0]};

  logic accept, fast_exit, msr_go;
  assign accept = req_valid && !busy;

  always_comb begin
    fast_exit = 1'b0;
    msr_go = 1'b0;
    if (c32 >= CR_RD_BASE && o_crr < CR_N)       fast_exit = cr_rd[o_crr[3:0]];
    else if (c32 >= CR_WR_BASE && o_crw < CR_N)  fast_exit = cr_wr[o_crw[3:0]];
    else if (c32 >= DR_RD_BASE && o_drr < DR_N)  fast_exit = dr_rd[o_drr[3:0]];
    else if (c32 >= DR_WR_BASE && o_drw < DR_N)  fast_exit = dr_wr[o_drw[3:0]];
    else if (c32 >= EXC_BASE && o_exc < EXC_N)   fast_exit = exc[o_exc[4:0]];
    else if (c32 == MSR_CODE) begin
      if (gen[MSR_BIT]) begin
        if (win_any) msr_go = 1'b1;
        else         fast_exit = 1'b1;
      end
    end
    else if (c32 >= GEN_BASE && o_gen < GEN_N)   fast_exit = gen[o_gen[5:0]];
    if (!guard_on) begin
      fast_exit = 1'b0;
      msr_go = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_rd <= '0; cr_wr <= '0; dr_rd <= '0; dr_wr <= '0;
      exc <= '0; gen <= '0; map_base <= '0;
      busy <= 1'b0; mem_rd <= 1'b0; mem_addr <= '0; pend_bit <= '0;
      dec_valid <= 1'b0; dec_exit <= 1'b0; dec_code <= '0; dec_param <= '0;
    end else begin
      dec_valid <= 1'b0;
      mem_rd <= 1'b0;
      if (ld) begin
        cr_rd <= ld_cr_rd; cr_wr <= ld_cr_wr;
        dr_rd <= ld_dr_rd; dr_wr <= ld_dr_wr;
        exc <= ld_exc; gen <= ld_gen; map_base <= ld_map_base;
      end
      if (accept) begin
        dec_code <= req_code;
        dec_param <= req_param;
        if (msr_go) begin
          busy <= 1'b1;
          mem_rd <= 1'b1;
          mem_addr <= map_base + ADDR_W'(idx[14:2]);
          pend_bit <= {idx[1:0], 1'b0} + {2'b00, req_param[0]};
        end else begin
          dec_valid <= 1'b1;
          dec_exit <= fast_exit;
        end
      end else if (busy && mem_rvalid) begin
        busy <= 1'b0;
        dec_valid <= 1'b1;
        dec_exit <= mem_rdata[pend_bit];
      end
    end
  end

  p_read_only_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
  p_busy_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> (busy && !dec_valid));
  p_result_after_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rvalid) |=> (dec_valid && !busy));
  p_disabled_no_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !guard_on) |=> (dec_valid && !dec_exit && !mem_rd));
  p_decision_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !busy);
  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !(req_valid && !busy)) |=> !dec_valid);
endmodule

// File: tb/tb_guest_exit_filter.sv
module tb_guest_exit_filter;
  localparam int CLK_P = 10;
  localparam int CW = 12;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0, guard_on = 0, ld = 0;
  logic [15:0] ld_cr_rd = 0, ld_cr_wr = 0, ld_dr_rd = 0, ld_dr_wr = 0;
  logic [31:0] ld_exc = 0;
  logic [63:0] ld_gen = 0;
  logic [AW-1:0] ld_map_base = 0;
  logic req_valid = 0;
  logic [CW-1:0] req_code = 0;
  logic [63:0] req_param = 0;
  logic [31:0] req_msr = 0;
  logic busy, mem_rd, dec_valid, dec_exit;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 0;
  logic [7:0] mem_rdata = 0;
  logic [CW-1:0] dec_code;
  logic [63:0] dec_param;

  guest_exit_filter dut (
    .clk(clk), .rst_n(rst_n), .guard_on(guard_on), .ld(ld),
    .ld_cr_rd(ld_cr_rd), .ld_cr_wr(ld_cr_wr), .ld_dr_rd(ld_dr_rd), .ld_dr_wr(ld_dr_wr),
    .ld_exc(ld_exc), .ld_gen(ld_gen), .ld_map_base(ld_map_base),
    .req_valid(req_valid), .req_code(req_code), .req_param(req_param), .req_msr(req_msr),
    .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .dec_valid(dec_valid), .dec_exit(dec_exit), .dec_code(dec_code), .dec_param(dec_param));

  always #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    logic [31:0] v;
    v = (a * 32'd157) ^ (a >> 7) ^ 32'h5A;
    return v[7:0];
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model state
  logic [15:0] m_crr = 0, m_crw = 0, m_drr = 0, m_drw = 0;
  logic [31:0] m_exc = 0;
  logic [63:0] m_gen = 0;
  logic [31:0] m_base = 0;
  bit m_loaded = 0, ld_prev = 0;
  bit e_valid = 0, e_exit = 0, e_busy = 0, e_mrd = 0;
  logic [31:0] e_addr = 0;
  logic [CW-1:0] e_code = 0;
  logic [63:0] e_param = 0;
  int m_pbit = 0;
  string e_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_crr = 0; m_crw = 0; m_drr = 0; m_drw = 0; m_exc = 0; m_gen = 0; m_base = 0;
      e_valid = 0; e_busy = 0; e_mrd = 0; e_tag = "R1"; m_loaded = 0; ld_prev = 0;
    end else begin
      int c;
      longint n, idx;
      e_valid = 0; e_mrd = 0; e_tag = "R11";
      c = int'(req_code);
      if (req_valid && !e_busy) begin
        e_code = req_code; e_param = req_param;
        e_valid = 1; e_exit = 0;
        if (!guard_on) e_tag = "R2";
        else if (c <= 8) begin e_exit = m_crr[c]; e_tag = "R3"; end
        else if (c >= 16 && c <= 24) begin e_exit = m_crw[c-16]; e_tag = "R3"; end
        else if (c >= 32 && c <= 39) begin e_exit = m_drr[c-32]; e_tag = "R4"; end
        else if (c >= 48 && c <= 55) begin e_exit = m_drw[c-48]; e_tag = "R4"; end
        else if (c >= 64 && c <= 95) begin e_exit = m_exc[c-64]; e_tag = "R5"; end
        else if (c == 124) begin
          n = longint'(req_msr);
          idx = -1;
          if (n <= 64'h1FFF) idx = n;
          else if (n >= 64'hC0000000 && n <= 64'hC0001FFF) idx = 8192 + n - 64'hC0000000;
          else if (n >= 64'hC0010000 && n <= 64'hC0011FFF) idx = 16384 + n - 64'hC0010000;
          if (!m_gen[28]) e_tag = "R7";
          else if (idx < 0) begin e_exit = 1; e_tag = "R10"; end
          else begin
            e_valid = 0; e_busy = 1; e_mrd = 1; e_tag = "R8";
            e_addr = m_base + 32'((2 * idx) / 8);
            m_pbit = int'((2 * idx) % 8) + int'(req_param[0]);
          end
        end
        else if (c >= 96 && c <= 159) begin e_exit = m_gen[c-96]; e_tag = "R6"; end
        else e_tag = "R6";
        if (guard_on && !m_loaded) e_tag = "R1";
        if (ld_prev) e_tag = "R13";
      end else if (e_busy && mem_rvalid) begin
        e_busy = 0; e_valid = 1; e_tag = "R9";
        e_exit = mem_byte(e_addr)[m_pbit];
      end
      ld_prev = ld;
      if (ld) begin
        m_crr = ld_cr_rd; m_crw = ld_cr_wr; m_drr = ld_dr_rd; m_drw = ld_dr_wr;
        m_exc = ld_exc; m_gen = ld_gen; m_base = ld_map_base; m_loaded = 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy === e_busy, "R11", "busy", longint'(busy), longint'(e_busy));
      chk(mem_rd === e_mrd, e_tag, "mem_rd", longint'(mem_rd), longint'(e_mrd));
      if (e_mrd) chk(mem_addr === e_addr, "R8", "mem_addr", longint'(mem_addr), longint'(e_addr));
      chk(dec_valid === e_valid, e_tag, "dec_valid", longint'(dec_valid), longint'(e_valid));
      if (e_valid) begin
        chk(dec_exit === e_exit, e_tag, "dec_exit", longint'(dec_exit), longint'(e_exit));
        chk(dec_code === e_code, "R12", "dec_code", longint'(dec_code), longint'(e_code));
        chk(dec_param === e_param, "R12", "dec_param", longint'(dec_param), longint'(e_param));
      end
    end
  end

  // memory responder with a variable latency
  bit rd_wait = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr = 0;
  always @(negedge clk) begin
    mem_rvalid = 0;
    if (rd_wait) begin
      if (rd_cnt == 0) begin mem_rvalid = 1; mem_rdata = mem_byte(rd_addr); rd_wait = 0; end
      else rd_cnt--;
    end
    if (rst_n && mem_rd === 1'b1) begin
      rd_addr = mem_addr;
      rd_cnt = int'($urandom % 4);
      if (rd_cnt == 0) begin mem_rvalid = 1; mem_rdata = mem_byte(rd_addr); end
      else begin rd_cnt--; rd_wait = 1; end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic logic [31:0] pick_msr();
    logic [31:0] wbase;
    int w, k;
    w = int'($urandom % 4);
    k = int'($urandom % 6);
    wbase = (w == 0) ? 32'h0 : (w == 1) ? 32'hC0000000 : (w == 2) ? 32'hC0010000 : 32'h2000;
    case (k)
      0: return wbase;
      1: return wbase + 32'h1FFF;
      2: return wbase + 32'h2000;
      3: return wbase - 32'h1;
      default: return wbase + ($urandom % 32'h2000);
    endcase
  endfunction

  initial begin
    @(negedge clk);
    // R1: outputs quiet during and after reset
    repeat (3) begin
      @(negedge clk);
      chk(dec_valid === 1'b0 && busy === 1'b0 && mem_rd === 1'b0, "R1", "reset outputs",
          longint'({dec_valid, busy, mem_rd}), 0);
    end
    rst_n = 1;
    guard_on = 1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      ld = 0;
      if (i >= 40 && (i % 150) == 40) begin
        ld = 1;
        ld_cr_rd = 16'($urandom); ld_cr_wr = 16'($urandom);
        ld_dr_rd = 16'($urandom); ld_dr_wr = 16'($urandom);
        ld_exc = $urandom;
        ld_gen = {$urandom, $urandom};
        if (($urandom % 4) != 0) ld_gen[28] = 1'b1;
        ld_map_base = $urandom;
      end
      if ((i % 400) == 399) guard_on = ~guard_on;
      req_valid = ($urandom % 3) != 0;
      if (($urandom % 3) == 0) req_code = 12'd124;
      else req_code = 12'($urandom % 176);
      req_param = {$urandom, $urandom};
      req_msr = pick_msr();
    end
    @(negedge clk);
    req_valid = 0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule